// File: doc/BRIEF.md
# SPI Bit-Clock Divider

This block derives the serial bit clock of an SPI master from the main clock. The division has two stages. A power-of-two prescaler, chosen by a 2-bit select, divides by 2, 4, 8 or 16. An even divider follows it and divides by twice the value of a 6-bit rate field plus one. The overall divide ratio is therefore `(4 << sel) * (rate + 1)`. Legal settings run from 20 main cycles per bit up to 2048. A polarity input sets the idle level of the clock. Two single-cycle strobes mark the leading edge (leaving idle) and the trailing edge (returning to idle) for the shift engine.

The divider takes its settings only while it is disabled. Once enabled, it raises a ready flag after a short settling delay. The shift engine then asks for clock pulses with a run request. A combinational helper is also provided: it turns a requested divide ratio into the nearest legal select and rate pair, saturating at the fastest and slowest settings, so that software or a control block can program the fields directly.

Top module: `spi_bitclk_div`

## Requirements
- R1: Each half period of the bit clock, leading to trailing and trailing to leading, lasts `(2 << prescSel) * (rateField + 1)` main-clock cycles while run stays high.
- R2: With prescSel = 0 and rateField = 4 (the fastest setting) each half period is 10 cycles.
- R3: With prescSel = 3 and rateField = 63 (the slowest setting) each half period is 1024 cycles.
- R4: After reset the held settings are rateField = 4 and prescSel = 0. If enable is already high when reset is released, the block runs at this setting whatever the field inputs show.
- R5: prescSel and rateField are captured on every clock edge at which enable is low. Changes made while enable is high have no effect until enable has been low for at least one edge.
- R6: ready goes high after the second rising edge at which enable is sampled high. It goes low in the same cycle that enable goes low.
- R7: A leading edge starts only while run is high. When run falls during the active half, that half still runs to its full length. After that the clock stays at the cpol level and no further leading edge occurs while run stays low.
- R8: leadStrobe is high for exactly one cycle, the first cycle in which sclk differs from cpol. trailStrobe is high for exactly the cycle in which sclk returns to cpol. The two are never high together.
- R9: The helper picks the smallest select d in 0..3 for which `fitRatio >> (d+2)` is at most 64, and sets fitRate to that quotient minus one. Examples: 100 gives (0,24), 260 gives (1,31), 1000 gives (2,61).
- R10: If `fitRatio >> 2` is below 5, the helper returns select 0 and rate 4.
- R11: If no select gives a quotient of at most 64, the helper returns select 3 and rate 63. fitRate always lies in 4..63.
- R12: Dropping enable aborts any pulse: one edge later sclk equals cpol and no strobe is raised for that abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Divider enable; low loads the settings |
| run | input | 1 | Pulse request from the shift engine |
| cpol | input | 1 | Idle level of sclk |
| prescSel | input | 2 | Prescaler select, divide by 2 << prescSel |
| rateField | input | 6 | Even-divider setting, legal 4..63 |
| sclk | output | 1 | Serial bit clock |
| leadStrobe | output | 1 | One-cycle mark of the edge leaving idle |
| trailStrobe | output | 1 | One-cycle mark of the edge returning to idle |
| ready | output | 1 | Divider settled after enable |
| fitRatio | input | 16 | Requested main-clock-to-bit-clock ratio for the helper |
| fitSel | output | 2 | Helper result: prescaler select |
| fitRate | output | 6 | Helper result: rate field |

## Verification
The checker assumes that cpol changes only while enable is low. It also assumes that rateField stays within its legal range of at least 4, so that every half period lasts well over one cycle. The bench changes polarity only inside its configuration task, with enable held low, and it programs only legal rate values into the divider. Out-of-range and saturating ratios are applied only to the helper, which has no such assumptions.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture settings, park the clock
    logic count;  // advance the divider chain
    logic clear;  // hold the divider chain at zero
  } ctrlStrobes_t;

endpackage

// File: rtl/spiclk_fit.sv
module spiclk_fit #(
  parameter int RATIO_W  = 16,
  parameter int SEL_W    = 2,
  parameter int RATE_W   = 6,
  parameter int RATE_MIN = 4,
  parameter int RATE_MAX = 63
) (
  input  logic [RATIO_W-1:0] fitRatio,
  output logic [SEL_W-1:0]   fitSel,
  output logic [RATE_W-1:0]  fitRate
);
  localparam int SEL_MAX = (1 << SEL_W) - 1;

  logic        found;
  int          selV;
  logic [31:0] quotV;
  logic [31:0] q;

  // Walk the prescaler choices from fastest to slowest; first fit wins.
  always_comb begin
    found = 1'b0;
    selV  = SEL_MAX;
    quotV = 32'(RATE_MAX + 1);
    q     = '0;
    for (int d = 0; d <= SEL_MAX; d++) begin
      q = 32'(fitRatio) >> (d + 2);
      if (!found) begin
        if (q < 32'(RATE_MIN + 1)) begin
          selV  = d;
          quotV = 32'(RATE_MIN + 1);
          found = 1'b1;
        end else if (q <= 32'(RATE_MAX + 1)) begin
          selV  = d;
          quotV = q;
          found = 1'b1;
        end
      end
    end
  end

  assign fitSel  = SEL_W'(selV);
  assign fitRate = RATE_W'(quotV - 32'd1);
endmodule

// File: rtl/spiclk_ctrl.sv
module spiclk_ctrl
  import spiclk_pkg::*;
#(
  parameter int READY_LAT = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         run,
  input  logic         phase,
  output ctrlStrobes_t ctrl,
  output logic         ready
);
  logic [READY_LAT-1:0] settleQ;
  logic                 readyNow;

  always_ff @(posedge clk) begin
    if (!rstN)        settleQ <= '0;
    else if (!enable) settleQ <= '0;
    else              settleQ <= {settleQ[READY_LAT-2:0], 1'b1};
  end

  assign readyNow   = settleQ[READY_LAT-1] & enable;
  assign ready      = readyNow;

  // An active half always finishes; an idle half starts only on request.
  assign ctrl.load  = ~enable;
  assign ctrl.count = readyNow & (run | phase);
  assign ctrl.clear = ~ctrl.count;
endmodule

// File: rtl/spiclk_datapath.sv
module spiclk_datapath
  import spiclk_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int RATE_W   = 6,
  parameter int RATE_RST = 4,
  parameter int PRESC_W  = (1 << SEL_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctrl,
  input  logic [SEL_W-1:0]  selIn,
  input  logic [RATE_W-1:0] rateIn,
  input  logic              cpol,
  output logic              sclk,
  output logic              leadStrobe,
  output logic              trailStrobe,
  output logic              phase
);
  logic [SEL_W-1:0]   selQ;
  logic [RATE_W-1:0]  rateQ;
  logic [PRESC_W-1:0] prescQ;
  logic [PRESC_W-1:0] prescTop;
  logic [RATE_W-1:0]  rateCntQ;
  logic               prescWrap;
  logic               halfDone;
  logic               edgeNow;
  logic               phaseQ;
  logic               leadQ;
  logic               trailQ;

  // Settings are captured only while disabled
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ  <= '0;
      rateQ <= RATE_W'(RATE_RST);
    end else if (ctrl.load) begin
      selQ  <= selIn;
      rateQ <= rateIn;
    end
  end

  assign prescTop  = PRESC_W'((32'd2 << selQ) - 32'd1);
  assign prescWrap = (prescQ == prescTop);
  assign halfDone  = prescWrap && (rateCntQ == rateQ);
  assign edgeNow   = ctrl.count && halfDone;

  // Stage one: power-of-two prescaler; stage two: rate counter on its ticks
  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      prescQ   <= '0;
      rateCntQ <= '0;
    end else if (ctrl.count) begin
      prescQ <= prescWrap ? '0 : prescQ + 1'b1;
      if (prescWrap) rateCntQ <= halfDone ? '0 : rateCntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.load) begin
      phaseQ <= 1'b0;
      leadQ  <= 1'b0;
      trailQ <= 1'b0;
    end else begin
      if (edgeNow) phaseQ <= ~phaseQ;
      leadQ  <= edgeNow & ~phaseQ;
      trailQ <= edgeNow & phaseQ;
    end
  end

  assign sclk        = phaseQ ^ cpol;
  assign leadStrobe  = leadQ;
  assign trailStrobe = trailQ;
  assign phase       = phaseQ;
endmodule

// File: rtl/spi_bitclk_div.sv
module spi_bitclk_div
  import spiclk_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter int RATE_W    = 6,
  parameter int RATIO_W   = 16,
  parameter int RATE_MIN  = 4,
  parameter int RATE_MAX  = 63,
  parameter int READY_LAT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               run,
  input  logic               cpol,
  input  logic [SEL_W-1:0]   prescSel,
  input  logic [RATE_W-1:0]  rateField,
  output logic               sclk,
  output logic               leadStrobe,
  output logic               trailStrobe,
  output logic               ready,
  input  logic [RATIO_W-1:0] fitRatio,
  output logic [SEL_W-1:0]   fitSel,
  output logic [RATE_W-1:0]  fitRate
);
  ctrlStrobes_t ctrl;
  logic         phase;

  spiclk_ctrl #(.READY_LAT(READY_LAT)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .run(run),
    .phase(phase), .ctrl(ctrl), .ready(ready)
  );

  spiclk_datapath #(.SEL_W(SEL_W), .RATE_W(RATE_W), .RATE_RST(RATE_MIN)) uPath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .selIn(prescSel), .rateIn(rateField),
    .cpol(cpol), .sclk(sclk), .leadStrobe(leadStrobe),
    .trailStrobe(trailStrobe), .phase(phase)
  );

  spiclk_fit #(.RATIO_W(RATIO_W), .SEL_W(SEL_W), .RATE_W(RATE_W),
               .RATE_MIN(RATE_MIN), .RATE_MAX(RATE_MAX)) uFit (
    .fitRatio(fitRatio), .fitSel(fitSel), .fitRate(fitRate)
  );
endmodule

// File: rtl/spiclk_chk.sv
module spiclk_chk #(
  parameter int RATE_W   = 6,
  parameter int RATE_MIN = 4,
  parameter int RATE_MAX = 63
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              run,
  input logic              cpol,
  input logic              sclk,
  input logic              leadStrobe,
  input logic              trailStrobe,
  input logic              ready,
  input logic [RATE_W-1:0] fitRate
);
  // R6
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (enable && $past(enable)));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(leadStrobe && trailStrobe));

  // R8
  sclk_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && $stable(cpol) && (sclk != $past(sclk)))
      |-> (leadStrobe || trailStrobe));

  // R8
  lead_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    leadStrobe |-> (sclk != cpol));

  // R7
  lead_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    leadStrobe |-> $past(run));

  // R7
  no_short_chk: assert property (@(posedge clk) disable iff (!rstN)
    leadStrobe |=> !trailStrobe);

  // R12
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!enable) && $stable(cpol)) |-> (sclk == cpol && !leadStrobe && !trailStrobe));

  // R11
  fit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fitRate >= RATE_W'(RATE_MIN)) && (fitRate <= RATE_W'(RATE_MAX)));
endmodule

bind spi_bitclk_div spiclk_chk #(.RATE_W(RATE_W), .RATE_MIN(RATE_MIN), .RATE_MAX(RATE_MAX)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .run(run), .cpol(cpol), .sclk(sclk),
  .leadStrobe(leadStrobe), .trailStrobe(trailStrobe), .ready(ready), .fitRate(fitRate)
);

// File: tb/tb_spi_bitclk_div.sv
module tb_spi_bitclk_div;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 5000;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        run = 1'b0;
  logic        cpol = 1'b0;
  logic [1:0]  prescSel = '0;
  logic [5:0]  rateField = 6'd4;
  logic        sclk, leadStrobe, trailStrobe, ready;
  logic [15:0] fitRatio = 16'd20;
  logic [1:0]  fitSel;
  logic [5:0]  fitRate;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_bitclk_div dut (
    .clk(clk), .rstN(rstN), .enable(enable), .run(run), .cpol(cpol),
    .prescSel(prescSel), .rateField(rateField), .sclk(sclk),
    .leadStrobe(leadStrobe), .trailStrobe(trailStrobe), .ready(ready),
    .fitRatio(fitRatio), .fitSel(fitSel), .fitRate(fitRate)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic configure(input logic [1:0] s, input logic [5:0] r, input logic pol);
    @(negedge clk);
    enable = 1'b0; run = 1'b0;
    prescSel = s; rateField = r; cpol = pol;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic waitLead(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < WAIT_LIMIT && !seen; i++) begin
      @(negedge clk);
      if (leadStrobe) seen = 1'b1;
    end
  endtask

  // Counts cycles lead->trail and trail->lead; checks levels at each edge
  task automatic measureHalves(input int expH, input string req);
    bit seen;
    int n;
    waitLead(seen);
    check(seen, req, int'(seen), 1);
    check(sclk != cpol, {req, " lead level (R8)"}, int'(sclk), int'(~cpol));
    n = 0;
    do begin @(negedge clk); n++; end while (!trailStrobe && n < WAIT_LIMIT);
    check(n == expH, {req, " active half"}, n, expH);
    check(sclk == cpol, {req, " trail level (R8)"}, int'(sclk), int'(cpol));
    n = 0;
    do begin @(negedge clk); n++; end while (!leadStrobe && n < WAIT_LIMIT);
    check(n == expH, {req, " idle half"}, n, expH);
  endtask

  task automatic testResetDefault();
    // R4: enable held high through reset, fields show slow values
    enable = 1'b1; prescSel = 2'd3; rateField = 6'd63; cpol = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(sclk == 1'b0 && !leadStrobe && !trailStrobe && !ready, "R4 reset outputs",
          int'({sclk, leadStrobe, trailStrobe, ready}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    run = 1'b1;
    measureHalves(10, "R4 default setting");
    run = 1'b0;
  endtask

  task automatic testReady();
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(!ready, "R6 low while disabled", int'(ready), 0);
    enable = 1'b1;
    @(negedge clk);
    check(!ready, "R6 not after first edge", int'(ready), 0);
    @(negedge clk);
    check(ready, "R6 high after second edge", int'(ready), 1);
    enable = 1'b0;
    #1;
    check(!ready, "R6 drops with enable", int'(ready), 0);
  endtask

  task automatic testPeriod(input logic [1:0] s, input logic [5:0] r, input string req);
    configure(s, r, 1'b0);
    run = 1'b1;
    measureHalves((2 << s) * (int'(r) + 1), req);
    run = 1'b0;
  endtask

  task automatic testLock();
    configure(2'd0, 6'd9, 1'b0);
    prescSel = 2'd2; rateField = 6'd40;   // R5: ignored while enabled
    run = 1'b1;
    measureHalves(20, "R5 change while enabled");
    configure(2'd2, 6'd40, 1'b0);
    run = 1'b1;
    measureHalves(8 * 41, "R5 taken after disable");
    run = 1'b0;
  endtask

  task automatic testRunDrop();
    bit seen;
    bit bad;
    int n;
    configure(2'd0, 6'd7, 1'b1);    // H = 16, idle high
    check(sclk == 1'b1, "R7 idle at cpol", int'(sclk), 1);
    run = 1'b1;
    waitLead(seen);
    run = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!trailStrobe && n < WAIT_LIMIT);
    check(n == 16, "R7 active half not shortened", n, 16);
    bad = 1'b0;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (leadStrobe || sclk != 1'b1) bad = 1'b1;
    end
    check(!bad, "R7 stays idle with run low", int'(bad), 0);
  endtask

  task automatic testAbort();
    bit seen;
    configure(2'd1, 6'd9, 1'b0);    // H = 40
    run = 1'b1;
    waitLead(seen);
    repeat (5) @(negedge clk);
    check(sclk == 1'b1, "R12 pulse active before abort", int'(sclk), 1);
    enable = 1'b0;
    @(negedge clk);
    check(sclk == 1'b0 && !trailStrobe && !leadStrobe, "R12 abort to idle",
          int'({sclk, trailStrobe, leadStrobe}), 0);
    run = 1'b0;
  endtask

  task automatic fitCase(input int ratio, input int es, input int er, input string req);
    fitRatio = 16'(ratio);
    #1;
    check(int'(fitSel) == es, {req, " sel"}, int'(fitSel), es);
    check(int'(fitRate) == er, {req, " rate"}, int'(fitRate), er);
  endtask

  task automatic testFit();
    fitCase(20,    0, 4,  "R9 ratio 20");
    fitCase(100,   0, 24, "R9 ratio 100");
    fitCase(256,   0, 63, "R9 ratio 256");
    fitCase(260,   1, 31, "R9 ratio 260");
    fitCase(1000,  2, 61, "R9 ratio 1000");
    fitCase(2048,  3, 63, "R9 ratio 2048");
    fitCase(10,    0, 4,  "R10 ratio 10");
    fitCase(0,     0, 4,  "R10 ratio 0");
    fitCase(5000,  3, 63, "R11 ratio 5000");
    fitCase(65535, 3, 63, "R11 ratio 65535");
  endtask

  initial begin
    testResetDefault();
    testReady();
    testPeriod(2'd0, 6'd4,  "R2 fastest");
    testPeriod(2'd1, 6'd12, "R1 sel1 rate12");
    testPeriod(2'd2, 6'd5,  "R1 sel2 rate5");
    testPeriod(2'd3, 6'd63, "R3 slowest");
    testLock();
    testRunDrop();
    testAbort();
    testFit();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule